// File: doc/BRIEF.md
# USB Full-Speed Frame Interval Timer

This block keeps the frame timing of a full-speed USB host. A strobe that arrives once per full-speed bit time drives a down-counter of the bit times left in the current frame. When that counter has reached zero, the next strobe ends the frame. At that point the block reloads the counter from the programmed interval and advances a 16-bit frame number. It also emits a one-cycle start-of-frame pulse and raises interrupt-request bits for start of frame and for frame-number overflow.

Software programs the frame length through a 32-bit interval word. The same word also carries a largest-data-packet budget and a toggle flag. A write lands in a staging copy at once, but the counting logic picks it up only at the next frame boundary. At that boundary the toggle is copied into the readable frame-number word. Software can compare the two toggles to learn that its new interval is now live. The packet budget that the scheduler sees is the value active for the current frame.

Top module: `usb_frame_timer`

## Requirements
- R1: After reset the remaining count is 0x2EDF and the frame number is 0. Both toggles are 0. The packet budget is 0x2428, which is (6 × (0x2EDF − 1200)) / 7. The interval word reads 0x24282EDF and the frame-number word reads 0x2EDF0000.
- R2: On each cycle with `bit_tick` high and a nonzero remaining count, the remaining count drops by one. Without `bit_tick`, the remaining count and the frame number hold.
- R3: A cycle with `bit_tick` high and a remaining count of 0 is a frame boundary. On the next cycle the frame number has advanced by one modulo 2^16 and the remaining count equals the staged interval. `sof_pulse` and `irq_req[4]` are high for exactly that cycle.
- R4: A write through `ivl_wr` shows up in `ivl_rdata` on the next cycle. Interval word fields: interval in bits 13:0, packet budget in bits 30:16, toggle in bit 31, and bits 15:14 read as 0. The write does not change the remaining count. A write in the same cycle as a frame boundary is used at the following boundary.
- R5: At every frame boundary the remaining-toggle (bit 31 of `fnum_rdata`) takes the staged interval toggle. The frame-number word holds the frame number in bits 15:0 and the remaining count in bits 29:16, and bit 30 reads 0.
- R6: `irq_req[11]` is high for one cycle when a frame boundary changes bit 15 of the frame number, that is from 0x7FFF to 0x8000 and from 0xFFFF to 0x0000. It is low otherwise.
- R7: `pkt_limit` changes only at a frame boundary, where it takes the staged packet budget.
- R8: All `irq_req` bits other than 4 and 11 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle strobe per full-speed bit time |
| ivl_wr | input | 1 | Write strobe for the interval word |
| ivl_wdata | input | 32 | Interval word write data |
| ivl_rdata | output | 32 | Staged interval word |
| fnum_rdata | output | 32 | Frame number, remaining count and remaining toggle |
| sof_pulse | output | 1 | One-cycle start-of-frame event |
| irq_req | output | 32 | Interrupt requests: bit 4 start of frame, bit 11 frame-number overflow |
| pkt_limit | output | 15 | Packet budget active in the current frame |

## Verification
The assertions check on every cycle the following behaviour of the counting logic:
- the remaining count drops by one per strobe and holds without one;
- a boundary advances the frame number, pulses start of frame and copies the toggle;
- an overflow request appears only when frame-number bit 15 flips;
- a staged write is captured exactly.

The bench's scenarios alone can show the rest:
- the reset values;
- that a write made mid-frame leaves the running frame's length alone;
- the ordering when a write lands on a boundary;
- a full 16-bit frame-number wrap with both overflow events;
- that the packet budget switches at the right frame.

// File: rtl/usb_frame_timer_pkg.sv
package usb_frame_timer_pkg;

    localparam int WORD_W    = 32;
    localparam int IVL_W     = 14;
    localparam int BUDGET_W  = 15;
    localparam int FNUM_W    = 16;
    localparam int BUDGET_LSB = 16;
    localparam int REM_LSB   = 16;
    localparam int TOGGLE_BIT = 31;
    localparam int SOF_IRQ_BIT = 4;
    localparam int OVF_IRQ_BIT = 11;
    localparam logic [IVL_W-1:0] IVL_RESET = 14'h2EDF;

    // budget = (6 * (interval - 1200)) / 7, kept to BUDGET_W bits
    function automatic logic [BUDGET_W-1:0] budget_of(input int ivl);
        int t;
        t = (6 * (ivl - 1200)) / 7;
        return BUDGET_W'(t);
    endfunction

    typedef struct packed {
        logic                toggle;
        logic [BUDGET_W-1:0] budget;
        logic [IVL_W-1:0]    ivl;
    } ivl_cfg_t;

endpackage

// File: rtl/ufc_ivl_stage.sv
module ufc_ivl_stage
    import usb_frame_timer_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr,
    input  ivl_cfg_t wr_cfg,
    output ivl_cfg_t stage
);

    typedef struct packed {
        ivl_cfg_t cfg;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) st_d.cfg = wr_cfg;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cfg.toggle <= 1'b0;
            st_q.cfg.budget <= budget_of(int'(IVL_RESET));
            st_q.cfg.ivl    <= IVL_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign stage = st_q.cfg;

    assert_stage_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (stage == $past(wr_cfg)));

    assert_stage_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(stage));

endmodule

// File: rtl/ufc_frame_ctr.sv
module ufc_frame_ctr
    import usb_frame_timer_pkg::*;
#(
    parameter int                IW       = IVL_W,
    parameter int                BW       = BUDGET_W,
    parameter int                NW       = FNUM_W,
    parameter logic [IW-1:0]     REM_INIT = IVL_RESET
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  ivl_cfg_t      stage,
    output logic [IW-1:0] rem,
    output logic [NW-1:0] fnum,
    output logic          rem_toggle,
    output logic [BW-1:0] budget,
    output logic          sof,
    output logic          ovf
);

    localparam int MSB = NW - 1;

    typedef struct packed {
        logic [IW-1:0] rem;
        logic [NW-1:0] fnum;
        logic          tgl;
        logic [BW-1:0] budget;
        logic          sof;
        logic          ovf;
    } ctr_t;

    ctr_t c_d, c_q;
    logic boundary;
    logic [NW-1:0] fnum_inc;

    assign boundary = tick && (c_q.rem == '0);
    assign fnum_inc = c_q.fnum + 1'b1;

    always_comb begin
        c_d     = c_q;
        c_d.sof = 1'b0;
        c_d.ovf = 1'b0;
        if (boundary) begin
            c_d.rem    = stage.ivl;
            c_d.fnum   = fnum_inc;
            c_d.tgl    = stage.toggle;
            c_d.budget = stage.budget;
            c_d.sof    = 1'b1;
            c_d.ovf    = fnum_inc[MSB] ^ c_q.fnum[MSB];
        end else if (tick) begin
            c_d.rem = c_q.rem - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q.rem    <= REM_INIT;
            c_q.fnum   <= '0;
            c_q.tgl    <= 1'b0;
            c_q.budget <= budget_of(int'(REM_INIT));
            c_q.sof    <= 1'b0;
            c_q.ovf    <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign rem        = c_q.rem;
    assign fnum       = c_q.fnum;
    assign rem_toggle = c_q.tgl;
    assign budget     = c_q.budget;
    assign sof        = c_q.sof;
    assign ovf        = c_q.ovf;

    assert_rem_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && rem != '0) |=> (rem == $past(rem) - 1'b1));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(rem) && $stable(fnum) && !sof));

    assert_frame_adv_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && rem == '0) |=> (sof && fnum == $past(fnum) + 1'b1 && rem == $past(stage.ivl)));

    assert_toggle_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && rem == '0) |=> (rem_toggle == $past(stage.toggle)));

    assert_ovf_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (sof && fnum[MSB] != $past(fnum[MSB])));

    assert_budget_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick && rem == '0) |=> $stable(budget));

endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer
    import usb_frame_timer_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_tick,
    input  logic                 ivl_wr,
    input  logic [WORD_W-1:0]    ivl_wdata,
    output logic [WORD_W-1:0]    ivl_rdata,
    output logic [WORD_W-1:0]    fnum_rdata,
    output logic                 sof_pulse,
    output logic [WORD_W-1:0]    irq_req,
    output logic [BUDGET_W-1:0]  pkt_limit
);

    ivl_cfg_t             wr_cfg, stage;
    logic [IVL_W-1:0]     rem;
    logic [FNUM_W-1:0]    fnum;
    logic                 rem_toggle, sof, ovf;
    logic                 unused_wbits;

    assign wr_cfg.toggle = ivl_wdata[TOGGLE_BIT];
    assign wr_cfg.budget = ivl_wdata[BUDGET_LSB +: BUDGET_W];
    assign wr_cfg.ivl    = ivl_wdata[IVL_W-1:0];
    assign unused_wbits  = ^ivl_wdata[BUDGET_LSB-1:IVL_W];

    ufc_ivl_stage u_stage (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (ivl_wr),
        .wr_cfg (wr_cfg),
        .stage  (stage)
    );

    ufc_frame_ctr #(
        .IW       (IVL_W),
        .BW       (BUDGET_W),
        .NW       (FNUM_W),
        .REM_INIT (IVL_RESET)
    ) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (bit_tick),
        .stage      (stage),
        .rem        (rem),
        .fnum       (fnum),
        .rem_toggle (rem_toggle),
        .budget     (pkt_limit),
        .sof        (sof),
        .ovf        (ovf)
    );

    always_comb begin
        ivl_rdata                           = '0;
        ivl_rdata[IVL_W-1:0]                = stage.ivl;
        ivl_rdata[BUDGET_LSB +: BUDGET_W]   = stage.budget;
        ivl_rdata[TOGGLE_BIT]               = stage.toggle;

        fnum_rdata                          = '0;
        fnum_rdata[FNUM_W-1:0]              = fnum;
        fnum_rdata[REM_LSB +: IVL_W]        = rem;
        fnum_rdata[TOGGLE_BIT]              = rem_toggle;

        irq_req                             = '0;
        irq_req[SOF_IRQ_BIT]                = sof;
        irq_req[OVF_IRQ_BIT]                = ovf;
    end

    assign sof_pulse = sof;

    assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(irq_req) <= 2 && $onehot0(irq_req & ~((32'd1 << SOF_IRQ_BIT) | (32'd1 << OVF_IRQ_BIT))) &&
        ((irq_req & ~((32'd1 << SOF_IRQ_BIT) | (32'd1 << OVF_IRQ_BIT))) == '0));

endmodule

// File: tb/sim_usb_frame_timer.sv
`timescale 1ns/1ps
module sim_usb_frame_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_tick = 1'b0;
    logic        ivl_wr = 1'b0;
    logic [31:0] ivl_wdata = '0;
    logic [31:0] ivl_rdata, fnum_rdata, irq_req;
    logic        sof_pulse;
    logic [14:0] pkt_limit;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    int ovf_seen = 0;

    // behavioural model state
    int m_rem, m_fn, m_frt, m_ivl, m_bud, m_tgl, m_bud_act, m_sof, m_ovf;

    always #4 clk = ~clk;

    usb_frame_timer u0 (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .ivl_wr(ivl_wr),
        .ivl_wdata(ivl_wdata), .ivl_rdata(ivl_rdata), .fnum_rdata(fnum_rdata),
        .sof_pulse(sof_pulse), .irq_req(irq_req), .pkt_limit(pkt_limit)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=0x%0h exp=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int exp_ivl;
        exp_ivl = (m_tgl << 31) | (m_bud << 16) | m_ivl;
        chk(int'(fnum_rdata[29:16]) == m_rem, "R2 remaining", int'(fnum_rdata[29:16]), m_rem);
        chk(int'(fnum_rdata[15:0]) == m_fn, "R3 frame number", int'(fnum_rdata[15:0]), m_fn);
        chk(int'(sof_pulse) == m_sof && int'(irq_req[4]) == m_sof, "R3 sof", int'(sof_pulse), m_sof);
        chk(int'(fnum_rdata[31]) == m_frt && fnum_rdata[30] == 1'b0, "R5 remaining toggle",
            int'(fnum_rdata[31:30]), m_frt << 1);
        chk(int'(irq_req[11]) == m_ovf, "R6 overflow", int'(irq_req[11]), m_ovf);
        chk(ivl_rdata == 32'(exp_ivl), "R4 interval word", int'(ivl_rdata), exp_ivl);
        chk(int'(pkt_limit) == m_bud_act, "R7 packet limit", int'(pkt_limit), m_bud_act);
        chk((irq_req & 32'hFFFF_F7EF) == '0, "R8 spare irq bits", int'(irq_req), int'(irq_req & 32'h0000_0810));
        if (irq_req[11]) ovf_seen++;
    endtask

    // drive at negedge, advance model, then compare after the next edge
    task automatic step(input bit tk, input bit wr, input logic [31:0] wd);
        bit bnd;
        int old;
        bit_tick = tk; ivl_wr = wr; ivl_wdata = wd;
        bnd = tk && (m_rem == 0);
        m_sof = 0; m_ovf = 0;
        if (bnd) begin
            old = m_fn;
            m_fn = (m_fn + 1) % 65536;
            m_rem = m_ivl; m_frt = m_tgl; m_bud_act = m_bud;
            m_sof = 1;
            m_ovf = ((old >> 15) & 1) != ((m_fn >> 15) & 1) ? 1 : 0;
        end else if (tk) begin
            m_rem = m_rem - 1;
        end
        if (wr) begin
            m_ivl = int'(wd[13:0]); m_bud = int'(wd[30:16]); m_tgl = int'(wd[31]);
        end
        @(posedge clk);
        @(negedge clk);
        bit_tick = 0; ivl_wr = 0;
        compare_all();
    endtask

    task automatic run_to_boundary();
        while (m_rem != 0) step(1, 0, '0);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        m_rem = 'h2EDF; m_fn = 0; m_frt = 0; m_ivl = 'h2EDF; m_bud = 'h2428;
        m_tgl = 0; m_bud_act = 'h2428; m_sof = 0; m_ovf = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values at the ports
        chk(ivl_rdata == 32'h2428_2EDF, "R1 interval word", int'(ivl_rdata), 32'h2428_2EDF);
        chk(fnum_rdata == 32'h2EDF_0000, "R1 frame word", int'(fnum_rdata), 32'h2EDF_0000);
        chk(pkt_limit == 15'h2428 && !sof_pulse && irq_req == '0, "R1 limit/events",
            int'(pkt_limit), 32'h2428);

        // R2: idle cycles hold
        for (int i = 0; i < 5; i++) step(0, 0, '0);
        // R2: sparse ticks
        for (int i = 0; i < 40; i++) step(i % 3 == 0, 0, '0);

        // R4: mid-frame write, toggle inverted, no tick in that cycle
        step(0, 1, {1'b1, 15'd100, 2'b00, 14'd5});
        for (int i = 0; i < 10; i++) step(1, 0, '0);
        // R4: second mid-frame write with a tick
        step(1, 1, {1'b1, 15'd100, 2'b11, 14'd5});
        run_to_boundary();
        step(1, 0, '0); // boundary: R5 toggle=1, R7 limit=100
        chk(fnum_rdata[31] == 1'b1, "R5 toggle copied", int'(fnum_rdata[31]), 1);
        chk(pkt_limit == 15'd100, "R7 new limit", int'(pkt_limit), 100);
        for (int i = 0; i < 30; i++) step(1, 0, '0);

        // R4: write in the same cycle as a boundary
        run_to_boundary();
        step(1, 1, {1'b0, 15'd7, 2'b00, 14'd0});
        chk(fnum_rdata[29:16] == 14'd5, "R4 boundary write deferred", int'(fnum_rdata[29:16]), 5);
        run_to_boundary();
        step(1, 0, '0);

        // R6: interval 0, one frame per tick, full frame-number wrap
        ovf_seen = 0;
        for (int i = 0; i < 66000; i++) begin
            step(1, 0, '0);
            if (fnum_rdata[15:0] == 16'h8000 && sof_pulse)
                chk(irq_req[11] == 1'b1, "R6 flip to 0x8000", int'(irq_req[11]), 1);
            if (fnum_rdata[15:0] == 16'h0000 && sof_pulse)
                chk(irq_req[11] == 1'b1, "R6 wrap to 0", int'(irq_req[11]), 1);
        end
        chk(ovf_seen == 2, "R6 overflow count", ovf_seen, 2);
        for (int i = 0; i < 4; i++) step(0, 0, '0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule